// File: doc/BRIEF.md
# Saturating Transmit Statistics Counters

This block counts transmit outcomes for an Ethernet MAC. When a frame leaves the transmit path, the MAC pulses a completion strobe for one cycle. With the strobe it gives the number of collisions the frame saw, a flag that is set if the frame ever deferred, and a flag for excessive deferral. The block keeps four 4-bit counters: one-collision frames, multi-collision frames, deferred frames and excessively deferred frames. It presents all four together as one 16-bit word.

The counters stop at 15 and do not wrap. While any counter holds 15, a level interrupt request is raised. Software reads the word by pulsing the read strobe. The read returns the current value, and all counters clear on the following edge. An event that arrives in the same cycle as the read is counted as 1, so it is not lost.

Top module: `tx_stat_cnt`

## Requirements
- R1: After reset all four counters are 0 and `irq_o` is low.
- R2: The word packs the counters in four nibbles. Bits 3:0 count frames completed with a collision count of exactly 1. Bits 7:4 count multi-collision frames. Bits 11:8 count deferred frames. Bits 15:12 count excessively deferred frames. A completion with a collision count of 1 adds one to bits 3:0.
- R3: A completion with a collision count from 2 to 16 adds one to bits 7:4. A collision count of 0, or above 16, changes neither collision counter. No completion moves both collision counters.
- R4: A completion with the deferred flag set adds exactly one to bits 11:8, whatever the collision count.
- R5: A completion with the excessive-deferral flag set adds exactly one to bits 15:12.
- R6: A counter at 15 stays at 15 on further events until it is read, and never wraps.
- R7: `irq_o` is high exactly while some counter holds 15. It stays high until a read clears the counters.
- R8: While `rd_i` is high, `stat_o` shows the current counts. On the next edge every counter clears to 0. A counter whose event occurs in the same cycle as the read becomes 1 instead.
- R9: When `done_i` is low, the collision count and both flags have no effect, and the counters hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle frame completion strobe |
| coll_i | input | 5 | Collision count of the completed frame |
| defer_i | input | 1 | Frame deferred at least once |
| xdefer_i | input | 1 | Frame saw excessive deferral |
| rd_i | input | 1 | Register read strobe; clears counters after the cycle |
| stat_o | output | 16 | Packed counter word |
| irq_o | output | 1 | Level interrupt: some counter at 15 |

## Verification
The collision count is tried at 0, 1, 2, 16 and 17. This separates the single-collision and multi-collision paths and shows that both ends of the multi-collision range count, while values outside the range count nothing. Each flag is applied both with and without the strobe, which shows that only the strobe gates counting. Twenty back-to-back single-collision events test saturation and the interrupt. A read issued in the same cycle as an event tells a plain clear apart from a clear that keeps the event.

// File: rtl/tx_stat_cnt.sv
module tx_stat_cnt #(
  parameter int CNT_W    = 4,
  parameter int COLL_W   = 5,
  parameter int MAX_COLL = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  logic [COLL_W-1:0]    coll_i,
  input  logic                 defer_i,
  input  logic                 xdefer_i,
  input  logic                 rd_i,
  output logic [4*CNT_W-1:0]   stat_o,
  output logic                 irq_o
);
  localparam int NCNT = 4;
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [NCNT-1:0] bump;
  logic [NCNT-1:0] full;

  assign bump[0] = done_i && (coll_i == COLL_W'(1));
  assign bump[1] = done_i && (coll_i >= COLL_W'(2)) && (coll_i <= COLL_W'(MAX_COLL));
  assign bump[2] = done_i && defer_i;
  assign bump[3] = done_i && xdefer_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (rd_i)
        cnt_q <= {{(CNT_W-1){1'b0}}, bump[g]};
      else if (bump[g] && cnt_q != SAT)
        cnt_q <= cnt_q + 1'b1;
    end
    assign stat_o[g*CNT_W +: CNT_W] = cnt_q;
    assign full[g] = (cnt_q == SAT);
  end

  assign irq_o = |full;
endmodule

// File: rtl/tx_stat_cnt_chk.sv
module tx_stat_cnt_chk #(
  parameter int CNT_W  = 4,
  parameter int COLL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done_i,
  input logic [COLL_W-1:0]  coll_i,
  input logic               rd_i,
  input logic [4*CNT_W-1:0] stat_o,
  input logic               irq_o
);
  for (genvar g = 0; g < 4; g++) begin : g_nib
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[g*CNT_W +: CNT_W] == '1 && !rd_i) |=> stat_o[g*CNT_W +: CNT_W] == '1);
    assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> (stat_o[g*CNT_W +: CNT_W] == $past(stat_o[g*CNT_W +: CNT_W]) ||
                 stat_o[g*CNT_W +: CNT_W] == $past(stat_o[g*CNT_W +: CNT_W]) + 1'b1));
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> stat_o[g*CNT_W +: CNT_W] <= CNT_W'(1));
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !rd_i) |=> $stable(stat_o));
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_i) |=> irq_o);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_i) |=> !irq_o);
  assert_coll_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !((stat_o[0 +: CNT_W] != $past(stat_o[0 +: CNT_W])) &&
                (stat_o[CNT_W +: CNT_W] != $past(stat_o[CNT_W +: CNT_W]))));
endmodule

bind tx_stat_cnt tx_stat_cnt_chk #(.CNT_W(CNT_W), .COLL_W(COLL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .coll_i(coll_i),
  .rd_i(rd_i), .stat_o(stat_o), .irq_o(irq_o)
);

// File: tb/tx_stat_cnt_tb.sv
module tx_stat_cnt_tb;
  logic clk = 0, rst_n = 0, done_i = 0, defer_i = 0, xdefer_i = 0, rd_i = 0;
  logic [4:0]  coll_i = '0;
  logic [15:0] stat_o;
  logic        irq_o;
  int checks = 0, errors = 0;
  int exp_c[4];
  bit finished = 0;

  always #10 clk = ~clk;

  tx_stat_cnt u_dut (.clk(clk), .rst_n(rst_n), .done_i(done_i), .coll_i(coll_i),
    .defer_i(defer_i), .xdefer_i(xdefer_i), .rd_i(rd_i), .stat_o(stat_o), .irq_o(irq_o));

  function automatic logic [15:0] packed_exp();
    return {4'(exp_c[3]), 4'(exp_c[2]), 4'(exp_c[1]), 4'(exp_c[0])};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_state(string req);
    bit any15 = 0;
    for (int i = 0; i < 4; i++) if (exp_c[i] == 15) any15 = 1;
    check(req, stat_o, packed_exp());
    check({req, " irq"}, {15'd0, irq_o}, {15'd0, any15});
  endtask

  task automatic step(bit dn, int coll, bit d, bit x, bit rd, string req);
    bit b[4];
    @(negedge clk);
    done_i = dn; coll_i = 5'(coll); defer_i = d; xdefer_i = x; rd_i = rd;
    #1;
    if (rd) check({req, " read value"}, stat_o, packed_exp());
    b[0] = dn && coll == 1;
    b[1] = dn && coll >= 2 && coll <= 16;
    b[2] = dn && d;
    b[3] = dn && x;
    @(negedge clk);
    done_i = 0; coll_i = '0; defer_i = 0; xdefer_i = 0; rd_i = 0;
    for (int i = 0; i < 4; i++) begin
      if (rd) exp_c[i] = b[i] ? 1 : 0;
      else if (b[i] && exp_c[i] < 15) exp_c[i]++;
    end
    #1 check_state(req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) exp_c[i] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check_state("R1 reset");
  endtask

  task automatic t_single;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, "R2 single collision");
  endtask

  task automatic t_multi;
    step(1, 2, 0, 0, 0, "R3 two collisions");
    step(1, 16, 0, 0, 0, "R3 sixteen collisions");
    step(1, 0, 0, 0, 0, "R3 zero collisions");
    step(1, 17, 0, 0, 0, "R3 seventeen collisions");
  endtask

  task automatic t_defer;
    step(1, 3, 1, 0, 0, "R4 deferred with retries");
    step(1, 0, 1, 0, 0, "R4 deferred clean");
  endtask

  task automatic t_xdefer;
    step(1, 0, 0, 1, 0, "R5 excessive deferral");
    step(1, 1, 1, 1, 0, "R5 all flags");
  endtask

  task automatic t_idle;
    step(0, 1, 1, 1, 0, "R9 no strobe");
    step(0, 5, 0, 1, 0, "R9 no strobe again");
  endtask

  task automatic t_read;
    step(0, 0, 0, 0, 1, "R8 read clear");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, "R6 saturate");
    step(0, 0, 0, 0, 0, "R7 irq held");
    step(1, 4, 0, 0, 0, "R7 irq held other event");
    step(0, 0, 0, 0, 1, "R7 read drops irq");
  endtask

  task automatic t_read_bump;
    step(1, 2, 0, 0, 0, "R8 preload");
    step(1, 2, 1, 0, 0, "R8 preload");
    step(1, 1, 1, 0, 1, "R8 read with event");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_defer();
    t_xdefer();
    t_idle();
    t_read();
    t_saturate();
    t_read_bump();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule